// File: doc/BRIEF.md
# Addressed Serial Volume Control Register

This block holds the volume settings for a stereo pair. A host sends 16-bit command words over three wires: data, clock and latch. The serial clock and latch lines are slow asynchronous inputs, and the block samples them in its own faster system clock domain. Each word carries a 2-bit device address, a 2-bit channel selector and an 8-bit attenuation code. On the rising edge of the latch line, the last word received is checked against two strap pins. If the address matches, the selected channel registers are loaded with the code.

Each channel drives three outputs:
- the raw 8-bit code it stores;
- a mute flag;
- a decoded attenuation in dB, from 0 to 80.

After reset both channels are muted. Several devices can share one serial link, each with its own strap setting. Straps and serial inputs that are left unconnected should be tied high on the board.

Top module: `sdvol_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, both channel codes read 0xFF and both mute flags are high.
- R2: On each detected rising edge of `ser_clk`, the sampled `ser_dat` bit enters the word, most significant bit (bit 15) first. Channel registers change only in the cycle after a detected rising edge of `ser_lat`.
- R3: A latch edge that follows fewer than 16 clock pulses since the previous latch edge (or since reset) changes nothing.
- R4: Bit 13 of the word is compared with `strap_a1` and bit 12 with `strap_a0`. If either bit differs, the latch edge changes nothing.
- R5: Bits 9:8 choose the target: 00 loads both channels, 01 loads left only, 10 loads right only, 11 loads neither.
- R6: Bits 7:0 are stored as the channel code. The mute flag is high exactly when the code is above 0x50 (80).
- R7: The dB output equals the code when it is 80 or below, and reads 80 when the channel is muted.
- R8: Bits 15, 14, 11 and 10 of the word have no effect on any output.
- R9: If the 16th clock edge and the latch edge are detected in the same system cycle, the bit of that clock edge is included and the word is applied.
- R10: A latch edge clears the bit count. A second latch edge with no clock pulses in between changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock line (asynchronous) |
| ser_lat | input | 1 | Serial latch line (asynchronous) |
| strap_a1 | input | 1 | Address strap compared with word bit 13 |
| strap_a0 | input | 1 | Address strap compared with word bit 12 |
| left_code | output | 8 | Stored left attenuation code |
| left_mute | output | 1 | Left channel muted |
| left_db | output | 7 | Left attenuation in dB (0..80) |
| right_code | output | 8 | Stored right attenuation code |
| right_mute | output | 1 | Right channel muted |
| right_db | output | 7 | Right attenuation in dB (0..80) |

## Verification
Shifting a bit in and acting on the latch can occur in the same system cycle. The bench provokes this by raising the serial clock for the 16th bit and the latch line together, so that both synchronisers report their edges in one cycle. The scoreboard expects the complete word to be applied, including that last bit. It also expects a further latch with no clock pulses in between to be ignored, because the count has been cleared.

// File: rtl/sdvol_ctrl.sv
module sdvol_ctrl #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 8,
  parameter int DB_W   = 7,
  parameter int MAX_DB = 80,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_dat,
  input  logic              ser_clk,
  input  logic              ser_lat,
  input  logic              strap_a1,
  input  logic              strap_a0,
  output logic [CODE_W-1:0] left_code,
  output logic              left_mute,
  output logic [DB_W-1:0]   left_db,
  output logic [CODE_W-1:0] right_code,
  output logic              right_mute,
  output logic [DB_W-1:0]   right_db
);
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int SEL_LO  = CODE_W;
  localparam int ADDR_LO = CODE_W + 4;
  localparam logic [CNT_W-1:0]  FULL    = CNT_W'(WORD_W);
  localparam logic [CODE_W-1:0] MUTE_CD = '1;
  localparam logic [CODE_W-1:0] TOP_CD  = CODE_W'(MAX_DB);

  logic [SYNC_N-1:0] dat_s, sck_s, lat_s;
  logic sck_q, lat_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dat_s <= '1; sck_s <= '1; lat_s <= '1;
      sck_q <= 1'b1; lat_q <= 1'b1;
    end else begin
      dat_s <= {dat_s[SYNC_N-2:0], ser_dat};
      sck_s <= {sck_s[SYNC_N-2:0], ser_clk};
      lat_s <= {lat_s[SYNC_N-2:0], ser_lat};
      sck_q <= sck_s[SYNC_N-1];
      lat_q <= lat_s[SYNC_N-1];
    end

  wire sck_rise = sck_s[SYNC_N-1] & ~sck_q;
  wire lat_rise = lat_s[SYNC_N-1] & ~lat_q;

  wire [WORD_W-1:0] shift_nx = sck_rise ? {shreg[WORD_W-2:0], dat_s[SYNC_N-1]} : shreg;
  wire [CNT_W-1:0]  cnt_nx   = (sck_rise && cnt != FULL) ? cnt + 1'b1 : cnt;

  wire [1:0] sel     = shift_nx[SEL_LO +: 2];
  wire       addr_ok = (shift_nx[ADDR_LO+1] == strap_a1) && (shift_nx[ADDR_LO] == strap_a0);
  wire       take    = lat_rise && (cnt_nx == FULL) && addr_ok;
  wire       wr_l    = take && (sel == 2'b00 || sel == 2'b01);
  wire       wr_r    = take && (sel == 2'b00 || sel == 2'b10);
  wire [CODE_W-1:0] code_in = shift_nx[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      shreg <= shift_nx;
      cnt   <= lat_rise ? '0 : cnt_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      left_code  <= MUTE_CD;
      right_code <= MUTE_CD;
    end else begin
      if (wr_l) left_code  <= code_in;
      if (wr_r) right_code <= code_in;
    end

  assign left_mute  = left_code  > TOP_CD;
  assign right_mute = right_code > TOP_CD;
  assign left_db    = left_mute  ? DB_W'(MAX_DB) : left_code[DB_W-1:0];
  assign right_db   = right_mute ? DB_W'(MAX_DB) : right_code[DB_W-1:0];

  // R2: shifting moves every bit up by one
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));

  // R2: settings move only after a latch edge
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(left_code) && $stable(right_code));

  // R3, R10: short word is ignored
  p_short_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && cnt_nx != FULL) |=> $stable(left_code) && $stable(right_code));

  // R4: wrong address is ignored
  p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !addr_ok) |=> $stable(left_code) && $stable(right_code));

  // R5: selector 11 touches neither channel
  p_sel_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && sel == 2'b11) |=> $stable(left_code) && $stable(right_code));

  // R10: counter never passes a full word
  p_cnt_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R7: decoded value stays in range
  p_db_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    left_db <= DB_W'(MAX_DB) && right_db <= DB_W'(MAX_DB));
endmodule

// File: tb/sim_sdvol_ctrl.sv
module sim_sdvol_ctrl;
  logic clk = 0, rst_n = 0;
  logic ser_dat = 0, ser_clk = 0, ser_lat = 0, strap_a1 = 0, strap_a0 = 0;
  logic [7:0] left_code, right_code;
  logic left_mute, right_mute;
  logic [6:0] left_db, right_db;

  int checks = 0, failures = 0;
  logic [7:0] exp_l = 8'hFF, exp_r = 8'hFF;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sdvol_ctrl u0 (.clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .ser_lat(ser_lat), .strap_a1(strap_a1), .strap_a0(strap_a0),
    .left_code(left_code), .left_mute(left_mute), .left_db(left_db),
    .right_code(right_code), .right_mute(right_mute), .right_db(right_db));

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int dbof(logic [7:0] c);
    return (c > 8'd80) ? 80 : int'(c);
  endfunction

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "left_code", int'(left_code), int'(e[15:8]));
      cmp(t, "right_code", int'(right_code), int'(e[7:0]));
      cmp(t, "left_mute", int'(left_mute), int'(e[15:8] > 8'd80));
      cmp(t, "right_mute", int'(right_mute), int'(e[7:0] > 8'd80));
      cmp(t, "left_db", int'(left_db), dbof(e[15:8]));
      cmp(t, "right_db", int'(right_db), dbof(e[7:0]));
    end
  end

  task automatic expect_now(string tag);
    exp_q.push_back({exp_l, exp_r});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic pulse_latch();
    repeat (2) @(negedge clk);
    ser_lat = 1;
    repeat (3) @(negedge clk);
    ser_lat = 0;
  endtask

  // sends the low n bits of w, MSB first; coinc raises latch with the last clock
  task automatic send(logic [15:0] w, int n, bit coinc, string tag);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) ser_dat = w[i];
      repeat (2) @(negedge clk);
      ser_clk = 1;
      if (coinc && i == 0) ser_lat = 1;
      repeat (3) @(negedge clk);
      ser_clk = 0;
      ser_lat = 0;
    end
    if (!coinc) pulse_latch();
    repeat (8) @(negedge clk);
    if (n >= 16 && w[13] == strap_a1 && w[12] == strap_a0) begin
      if (w[9:8] == 2'b00 || w[9:8] == 2'b01) exp_l = w[7:0];
      if (w[9:8] == 2'b00 || w[9:8] == 2'b10) exp_r = w[7:0];
    end
    expect_now(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    expect_now("R1 after reset");
    send(16'h0014, 16, 0, "R5 R6 both 20dB");
    send(16'h0150, 16, 0, "R6 left 80dB boundary");
    send(16'h0251, 16, 0, "R6 right 0x51 mute");
    send(16'h0101, 16, 0, "R2 msb first left 1");
    send(16'h0300, 16, 0, "R5 select 11 none");
    send(16'h1000, 16, 0, "R4 address mismatch");
    strap_a1 = 1; strap_a0 = 0;
    send(16'h2007, 16, 0, "R4 strap 10 match");
    send(16'h0009, 16, 0, "R4 old address now mismatch");
    send(16'hEC33, 16, 0, "R8 dont care bits set");
    send(16'h2222, 15, 0, "R3 short word");
    send(16'h223C, 16, 1, "R9 coincident edges");
    send(16'h20FF, 16, 0, "R6 code FF mute");
    send(16'h2145, 16, 0, "R7 left 69dB");
    pulse_latch();
    repeat (8) @(negedge clk);
    expect_now("R10 latch without clocks");
    rst_n = 0;
    exp_l = 8'hFF; exp_r = 8'hFF;
    repeat (2) @(negedge clk);
    expect_now("R1 second reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule